// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This unit gathers single-cycle event strobes, such as timer underflows, into a small flag register. Every strobe is recorded whatever the mask holds. A separate enable mask selects which recorded events may raise the interrupt request. The request comes from a sticky flip-flop. It rises one clock after a flag with its mask bit set is latched, and it stays high until software reads the flag register.

Software works through two plain strobed ports. A mask write uses its top bit to choose between setting and clearing: bit 7 high sets the selected mask bits, bit 7 low clears them, and the selection is the pattern of ones in the low bits. A flag read returns the flags in the low bits and the interrupt state in bit 7. The same read clears every flag and the request at the clock edge that ends the read cycle.

An event that lands in the same cycle as a read is passed straight into the read data, so software sees it. It is then dropped and raises no request, because the read has already delivered it. Neither port has a handshake. A strobe that is high during a cycle is acted on at the clock edge that ends that cycle.

Top module: `icu_flag_ctrl`

## Requirements
- R1: A high bit i of `evt_i` in a cycle without a read sets flag i at the next clock edge, whatever mask bit i holds.
- R2: When a flag whose mask bit is 1 is latched, `irq_o` is high from the cycle after the event on, with no mask write and no read in the event cycle.
- R3: `flag_rdata_o` carries the stored flags ORed with the current `evt_i` in bits 4..0. It carries the interrupt flip-flop state in bit 7, and bits 6..5 read 0.
- R4: A read (`flag_rd_i` high) clears all flags and `irq_o` at the next edge. An event in the read cycle shows in the read data but is neither stored nor able to raise `irq_o`.
- R5: Once `irq_o` is high, only a read clears it. Clearing mask bits leaves it high.
- R6: A mask write with bit 7 = 1 sets the mask bits selected by ones in bits 4..0. With bit 7 = 0 it clears them. Unselected mask bits keep their value.
- R7: Setting a mask bit while its flag is already pending raises `irq_o` from the cycle after the write.
- R8: Reset clears the flags, the mask and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event strobes, one per flag bit |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data: bit 7 set/clear, bits 4..0 select |
| flag_rd_i | input | 1 | Flag read strobe, clears on the edge |
| flag_rdata_o | output | 8 | Flag read data, interrupt state in bit 7 |
| irq_o | output | 1 | Sticky interrupt request, active high |

## Verification
Two functions can fall in the same cycle: an event strobe being recorded and a read clearing the register. A mask write can also coincide with a pending flag. The bench places a read two cycles before, one cycle before, in the same cycle as, and one and two cycles after a strobe. It does this for every flag bit. It judges the read data and `irq_o` against the expected race outcome: a same-cycle read returns the bit without bit 7 and suppresses the request, and a read one cycle later returns bit 7 set. Mask set and clear writes are swept over all 32 selection patterns for every event bit, and a mask clear issued while the request is high must not drop it.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SC_BIT  = DATA_W - 1;
  localparam int unsigned IRQ_BIT = DATA_W - 1;
endpackage

// File: rtl/icu_flag_bank.sv
module icu_flag_bank #(
  parameter int unsigned N_EVT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_i,
  output logic [N_EVT-1:0] flag_q,
  output logic [N_EVT-1:0] flag_view
);
  for (genvar g = 0; g < N_EVT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[g] <= 1'b0;
      else if (clr_i)  flag_q[g] <= 1'b0;
      else if (evt_i[g]) flag_q[g] <= 1'b1;
    end
    assign flag_view[g] = flag_q[g] | evt_i[g];
  end
endmodule

// File: rtl/icu_mask_reg.sv
module icu_mask_reg #(
  parameter int unsigned N_EVT = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [icu_pkg::DATA_W-1:0] wdata_i,
  output logic [N_EVT-1:0]          mask_q,
  output logic [N_EVT-1:0]          mask_nxt
);
  logic [N_EVT-1:0] sel;
  logic             set_mode;

  assign sel      = wdata_i[N_EVT-1:0];
  assign set_mode = wdata_i[icu_pkg::SC_BIT];

  always_comb begin
    mask_nxt = mask_q;
    if (wr_i) begin
      if (set_mode) mask_nxt = mask_q | sel;
      else          mask_nxt = mask_q & ~sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/icu_irq_ff.sv
module icu_irq_ff #(
  parameter int unsigned N_EVT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] flag_view,
  input  logic [N_EVT-1:0] mask_nxt,
  input  logic             clr_i,
  output logic             irq_q
);
  logic hit;

  assign hit = |(flag_view & mask_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else if (hit)   irq_q <= 1'b1;
  end
endmodule

// File: rtl/icu_flag_ctrl.sv
module icu_flag_ctrl #(
  parameter int unsigned N_EVT = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_EVT-1:0]           evt_i,
  input  logic                       mask_wr_i,
  input  logic [icu_pkg::DATA_W-1:0] mask_wdata_i,
  input  logic                       flag_rd_i,
  output logic [icu_pkg::DATA_W-1:0] flag_rdata_o,
  output logic                       irq_o
);
  localparam int unsigned PAD_W = icu_pkg::DATA_W - 1 - N_EVT;

  logic [N_EVT-1:0] flag_q;
  logic [N_EVT-1:0] flag_view;
  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] mask_nxt;
  logic             irq_q;

  icu_flag_bank #(.N_EVT(N_EVT)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_i     (flag_rd_i),
    .flag_q    (flag_q),
    .flag_view (flag_view)
  );

  icu_mask_reg #(.N_EVT(N_EVT)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (mask_wr_i),
    .wdata_i  (mask_wdata_i),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  icu_irq_ff #(.N_EVT(N_EVT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_view (flag_view),
    .mask_nxt  (mask_nxt),
    .clr_i     (flag_rd_i),
    .irq_q     (irq_q)
  );

  assign flag_rdata_o = {irq_q, {PAD_W{1'b0}}, flag_view};
  assign irq_o        = irq_q;
endmodule

// File: rtl/icu_flag_ctrl_chk.sv
module icu_flag_ctrl_chk #(
  parameter int unsigned N_EVT = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_EVT-1:0]           evt_i,
  input logic                       mask_wr_i,
  input logic [icu_pkg::DATA_W-1:0] mask_wdata_i,
  input logic                       flag_rd_i,
  input logic [icu_pkg::DATA_W-1:0] flag_rdata_o,
  input logic                       irq_o,
  input logic [N_EVT-1:0]           flag_q,
  input logic [N_EVT-1:0]           mask_q
);
  assert_evt_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_rd_i && |evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  assert_masked_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_rd_i && !mask_wr_i && |(flag_rdata_o[N_EVT-1:0] & mask_q)) |=> irq_o);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_i |=> (!irq_o && flag_q == '0));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !flag_rd_i) |=> irq_o);

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && mask_wdata_i[icu_pkg::SC_BIT]) |=>
      ((mask_q & $past(mask_wdata_i[N_EVT-1:0])) == $past(mask_wdata_i[N_EVT-1:0])));

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !mask_wdata_i[icu_pkg::SC_BIT]) |=>
      ((mask_q & $past(mask_wdata_i[N_EVT-1:0])) == '0));

  assert_irq_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdata_o[icu_pkg::IRQ_BIT] == irq_o);
endmodule

bind icu_flag_ctrl icu_flag_ctrl_chk #(.N_EVT(N_EVT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_i        (evt_i),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .flag_rd_i    (flag_rd_i),
  .flag_rdata_o (flag_rdata_o),
  .irq_o        (irq_o),
  .flag_q       (flag_q),
  .mask_q       (mask_q)
);

// File: tb/icu_flag_ctrl_tb.sv
module icu_flag_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic          mask_wr_i = 1'b0;
  logic [7:0]    mask_wdata_i = '0;
  logic          flag_rd_i = 1'b0;
  logic [7:0]    flag_rdata_o;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rd_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_flag_ctrl #(.N_EVT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .flag_rd_i(flag_rd_i),
    .flag_rdata_o(flag_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, capture read data, return just after posedge
  task automatic cyc(input logic [NE-1:0] e, input logic rd, input logic wr,
                     input logic [7:0] wd);
    @(negedge clk);
    evt_i = e; flag_rd_i = rd; mask_wr_i = wr; mask_wdata_i = wd;
    #1 rd_seen = flag_rdata_o;
    @(posedge clk);
    #1;
    evt_i = '0; flag_rd_i = 1'b0; mask_wr_i = 1'b0; mask_wdata_i = '0;
  endtask

  task automatic idle(); cyc('0, 1'b0, 1'b0, 8'h00); endtask
  task automatic rd();   cyc('0, 1'b1, 1'b0, 8'h00); endtask
  task automatic mw(input logic [7:0] d); cyc('0, 1'b0, 1'b1, d); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R8 irq after reset", {7'b0, irq_o}, 8'h00);
    chk("R8 flags after reset", flag_rdata_o, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    idle();
    // R8: mask starts cleared, so an event raises no request
    cyc(5'h1F, 1'b0, 1'b0, 8'h00);
    chk("R8 mask clear after reset", {7'b0, irq_o}, 8'h00);
    rd();
    chk("R1 unmasked flags stored", rd_seen, 8'h1F);

    // R6 sweep of set and clear patterns, R1/R2 per event bit
    for (int m = 0; m < 32; m++) begin
      for (int i = 0; i < NE; i++) begin
        logic en;
        en = m[i];
        mw(8'h1F); mw(8'h80 | 8'(m)); rd();
        cyc(5'(1 << i), 1'b0, 1'b0, 8'h00);
        chk("R2 R6 set pattern irq", {7'b0, irq_o}, {7'b0, en});
        rd();
        chk("R1 R3 read after event", rd_seen, {en, 2'b00, 5'(1 << i)});
        chk("R4 irq cleared by read", {7'b0, irq_o}, 8'h00);
        mw(8'h9F); mw(8'(m)); rd();
        cyc(5'(1 << i), 1'b0, 1'b0, 8'h00);
        chk("R6 clear pattern irq", {7'b0, irq_o}, {7'b0, ~en});
        rd();
      end
    end

    // Read race sweep around an event, per bit, mask fully on
    mw(8'h9F); rd();
    for (int i = 0; i < NE; i++) begin
      for (int off = -2; off <= 2; off++) begin
        logic [NE-1:0] b;
        b = 5'(1 << i);
        rd();
        if (off == -2) begin
          rd(); idle(); cyc(b, 1'b0, 1'b0, 8'h00);
          chk("R2 read two before, irq", {7'b0, irq_o}, 8'h01);
          rd();
          chk("R3 read after, data", rd_seen, {1'b1, 2'b00, b});
        end else if (off == -1) begin
          rd();
          chk("R4 read one before, data", rd_seen, 8'h00);
          cyc(b, 1'b0, 1'b0, 8'h00);
          chk("R2 read one before, irq", {7'b0, irq_o}, 8'h01);
          rd();
        end else if (off == 0) begin
          cyc(b, 1'b1, 1'b0, 8'h00);
          chk("R4 same cycle read data", rd_seen, {3'b000, b});
          chk("R4 same cycle irq suppressed", {7'b0, irq_o}, 8'h00);
          idle();
          chk("R4 same cycle irq stays low", {7'b0, irq_o}, 8'h00);
          rd();
          chk("R4 same cycle flag not stored", rd_seen, 8'h00);
        end else if (off == 1) begin
          cyc(b, 1'b0, 1'b0, 8'h00);
          chk("R2 irq one after event", {7'b0, irq_o}, 8'h01);
          rd();
          chk("R3 read one after data", rd_seen, {1'b1, 2'b00, b});
          chk("R4 irq cleared", {7'b0, irq_o}, 8'h00);
        end else begin
          cyc(b, 1'b0, 1'b0, 8'h00); idle();
          rd();
          chk("R3 read two after data", rd_seen, {1'b1, 2'b00, b});
        end
      end
    end

    // R5: clearing mask keeps the request
    rd();
    cyc(5'h04, 1'b0, 1'b0, 8'h00);
    mw(8'h1F);
    chk("R5 mask clear keeps irq", {7'b0, irq_o}, 8'h01);
    idle();
    chk("R5 irq still held", {7'b0, irq_o}, 8'h01);
    rd();
    chk("R5 read data with irq", rd_seen, 8'h84);
    chk("R5 only read clears", {7'b0, irq_o}, 8'h00);

    // R7: set mask for pending flag
    cyc(5'h08, 1'b0, 1'b0, 8'h00);
    chk("R7 pending unmasked no irq", {7'b0, irq_o}, 8'h00);
    mw(8'h88);
    chk("R7 mask set raises irq", {7'b0, irq_o}, 8'h01);
    rd();
    chk("R7 read data", rd_seen, 8'h88);

    // R3: all events together, spare bits zero
    mw(8'h9F);
    cyc(5'h1F, 1'b0, 1'b0, 8'h00);
    rd();
    chk("R3 all events data", rd_seen, 8'h9F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule